// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a small in-order processor core that runs a subset of a classic 32-bit three-operand integer instruction set. The subset is register add, subtract, AND and OR, add-immediate, OR-immediate, load word, store word and branch-if-equal. Every instruction moves through five stages in a fixed order: fetch, register read and decode, execute, memory, and writeback. Each stage owns one functional unit: the instruction port, the two register read ports, the ALU, the data port and the single register write port. No unit is used by two stages, and no instruction uses a unit twice. Control is decoded once in the decode stage. The decoded fields then ride down the pipeline beside the operands and a valid bit, and each stage acts on its own fields.

Both memories sit outside the core and are word-addressed. An instruction word is returned in the same cycle as its address. A load's data word is returned in the same cycle as the memory stage's address, and a store is committed on the next rising edge. There is no back-pressure on either port, so neither port needs a valid/ready handshake. Register writes are exposed as a write strobe with address and data. The core has no forwarding and no interlock. A program must place every consumer at least three instructions after the producer whose result it reads. Branches resolve in execute. The instruction right after a branch always executes. When the branch is taken, the instruction after that is cancelled.

Top module: `mpipe_core`

## Requirements
- R1: While reset is high the fetch address is 0 and neither the register write strobe nor the store strobe is asserted. All registers read as zero after reset.
- R2: Opcode 0x00 with bits 10:6 zero and function code 0x20 (add), 0x22 (subtract), 0x24 (AND) or 0x25 (OR) writes rs op rt into register rd (bits 15:11). rs is bits 25:21 and rt is bits 20:16.
- R3: Opcode 0x08 writes rs plus the sign-extended 16-bit immediate into rt. Opcode 0x0D writes rs OR the zero-extended immediate into rt.
- R4: Opcode 0x23 writes the data word at byte address rs plus the sign-extended immediate into rt. Opcode 0x2B performs no register write.
- R5: Every register write appears on the write port in the fourth cycle after the instruction was fetched. ALU results therefore wait through the memory stage, exactly as loads do. Writes come at most one per cycle and in program order.
- R6: Register 0 reads as zero. A write that targets it never raises the write strobe and has no effect.
- R7: Opcode 0x04 with equal operands redirects fetch to (branch address + 4) + (sign-extended offset shifted left by 2). The one instruction after the branch executes. The instruction after that is cancelled, even when it is also the target.
- R8: Opcode 0x04 with unequal operands lets both following instructions execute in sequence.
- R9: An instruction placed three positions after the producer of one of its sources reads the new value, because the register file passes a same-cycle write through to the read.
- R10: Any encoding that is not listed in R2 to R4, R7 or R8 passes through as a no-operation.
- R11: A store drives word address (rs + sign-extended immediate) / 4 and data rt on the data port with the store strobe, three cycles after its fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | IMEM_AW | Word address of the instruction being fetched |
| imem_data | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | DMEM_AW | Word address of the memory-stage access |
| dmem_we | output | 1 | Store strobe, committed at the next rising edge |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Data word at dmem_addr, same cycle |
| wr_en | output | 1 | Register write strobe (never for register 0) |
| wr_addr | output | 5 | Register being written |
| wr_data | output | 32 | Value being written |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a register write from writeback and a decode-stage read of that same register. Test programs place consumers exactly three slots after their producers, and the bench's own instruction-level model expects the fresh value. The second pair is a taken branch and the fetch it overrides. One program puts the target exactly at the cancelled slot, so the same word is fetched twice. The model then expects the first fetch to leave no trace and the second fetch to write once, in the cycle the slot count predicts. Randomly generated straight-line programs mix loads, stores and ALU operations that obey the spacing rule. Every write is compared with the model on its address, data and arrival cycle.

// File: rtl/mpipe_pkg.sv
package mpipe_pkg;

  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int NREG   = 1 << REG_AW;

  localparam logic [5:0] OP_REG  = 6'h00;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_ORI  = 6'h0D;
  localparam logic [5:0] OP_LW   = 6'h23;
  localparam logic [5:0] OP_SW   = 6'h2B;
  localparam logic [5:0] OP_BEQ  = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_OR  = 2'd3
  } alu_op_e;

  // Decoded control that travels with the instruction.
  typedef struct packed {
    alu_op_e alu;
    logic    use_imm;
    logic    branch;
    logic    mem_rd;
    logic    mem_wr;
    logic    reg_wr;
  } ctrl_t;

endpackage

// File: rtl/mpipe_decode.sv
module mpipe_decode
  import mpipe_pkg::*;
(
  input  logic [5:0]        op,
  input  logic [4:0]        shamt,
  input  logic [5:0]        fn,
  input  logic [REG_AW-1:0] rt,
  input  logic [REG_AW-1:0] rd,
  input  logic [15:0]       imm16,
  output logic              legal,
  output ctrl_t             ctrl,
  output logic [REG_AW-1:0] dest,
  output logic [XLEN-1:0]   imm
);

  logic zext;

  always_comb begin
    ctrl  = '0;
    legal = 1'b0;
    zext  = 1'b0;
    dest  = rt;
    case (op)
      OP_REG: begin
        dest        = rd;
        ctrl.reg_wr = 1'b1;
        if (shamt == 5'd0) begin
          case (fn)
            FN_ADD: begin legal = 1'b1; ctrl.alu = ALU_ADD; end
            FN_SUB: begin legal = 1'b1; ctrl.alu = ALU_SUB; end
            FN_AND: begin legal = 1'b1; ctrl.alu = ALU_AND; end
            FN_OR:  begin legal = 1'b1; ctrl.alu = ALU_OR;  end
            default: legal = 1'b0;
          endcase
        end
      end
      OP_ADDI: begin
        legal        = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.reg_wr  = 1'b1;
      end
      OP_ORI: begin
        legal        = 1'b1;
        zext         = 1'b1;
        ctrl.alu     = ALU_OR;
        ctrl.use_imm = 1'b1;
        ctrl.reg_wr  = 1'b1;
      end
      OP_LW: begin
        legal        = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.mem_rd  = 1'b1;
        ctrl.reg_wr  = 1'b1;
      end
      OP_SW: begin
        legal        = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.mem_wr  = 1'b1;
      end
      OP_BEQ: begin
        legal       = 1'b1;
        ctrl.branch = 1'b1;
      end
      default: legal = 1'b0;
    endcase
    imm = zext ? {16'h0000, imm16} : {{16{imm16[15]}}, imm16};
  end

endmodule

// File: rtl/mpipe_regfile.sv
module mpipe_regfile
  import mpipe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] ra1,
  input  logic [REG_AW-1:0] ra2,
  output logic [XLEN-1:0]   rd1,
  output logic [XLEN-1:0]   rd2,
  input  logic              we,
  input  logic [REG_AW-1:0] wa,
  input  logic [XLEN-1:0]   wd
);

  logic [XLEN-1:0] regs [NREG];

  assign regs[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (we && wa == REG_AW'(g))
        regs[g] <= wd;
    end
  end

  // Write-first read: a same-cycle write is visible to decode.
  always_comb begin
    rd1 = regs[ra1];
    rd2 = regs[ra2];
    if (we && wa != '0 && wa == ra1) rd1 = wd;
    if (we && wa != '0 && wa == ra2) rd2 = wd;
  end

  a_r6_zero_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (ra1 == '0) |-> (rd1 == '0));

  a_r9_write_passes_through: assert property (@(posedge clk) disable iff (rst)
    (we && wa != '0 && wa == ra2) |-> (rd2 == wd));

endmodule

// File: rtl/mpipe_alu.sv
module mpipe_alu
  import mpipe_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/mpipe_core.sv
module mpipe_core
  import mpipe_pkg::*;
#(
  parameter int IMEM_AW = 10,
  parameter int DMEM_AW = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [IMEM_AW-1:0]   imem_addr,
  input  logic [XLEN-1:0]      imem_data,
  output logic [DMEM_AW-1:0]   dmem_addr,
  output logic                 dmem_we,
  output logic [XLEN-1:0]      dmem_wdata,
  input  logic [XLEN-1:0]      dmem_rdata,
  output logic                 wr_en,
  output logic [REG_AW-1:0]    wr_addr,
  output logic [XLEN-1:0]      wr_data
);

  localparam int PC_W = IMEM_AW + 2;
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

  // ---------------- fetch ----------------
  logic [PC_W-1:0] pc;
  logic            br_take;
  logic [PC_W-1:0] br_target;

  logic            id_valid;
  logic [XLEN-1:0] id_instr;
  logic [PC_W-1:0] id_pc4;

  assign imem_addr = pc[PC_W-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      id_valid <= 1'b0;
      id_instr <= '0;
      id_pc4   <= '0;
    end else begin
      pc       <= br_take ? br_target : pc + PC_STEP;
      // A taken branch in execute cancels the word fetched this cycle.
      id_valid <= !br_take;
      id_instr <= imem_data;
      id_pc4   <= pc + PC_STEP;
    end
  end

  // ---------------- decode / register read ----------------
  logic              id_legal;
  ctrl_t             id_ctrl;
  logic [REG_AW-1:0] id_dest;
  logic [XLEN-1:0]   id_imm;
  logic [XLEN-1:0]   id_a, id_b;

  mpipe_decode u_dec (
    .op    (id_instr[31:26]),
    .shamt (id_instr[10:6]),
    .fn    (id_instr[5:0]),
    .rt    (id_instr[20:16]),
    .rd    (id_instr[15:11]),
    .imm16 (id_instr[15:0]),
    .legal (id_legal),
    .ctrl  (id_ctrl),
    .dest  (id_dest),
    .imm   (id_imm)
  );

  logic              wb_valid;
  logic              wb_rw;
  logic [REG_AW-1:0] wb_dest;
  logic [XLEN-1:0]   wb_m;

  mpipe_regfile u_rf (
    .clk (clk),
    .rst (rst),
    .ra1 (id_instr[25:21]),
    .ra2 (id_instr[20:16]),
    .rd1 (id_a),
    .rd2 (id_b),
    .we  (wr_en),
    .wa  (wr_addr),
    .wd  (wr_data)
  );

  logic              ex_valid;
  ctrl_t             ex_ctrl;
  logic [XLEN-1:0]   ex_a, ex_b, ex_imm;
  logic [REG_AW-1:0] ex_dest;
  logic [PC_W-1:0]   ex_pc4;

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_valid <= 1'b0;
      ex_ctrl  <= '0;
      ex_a     <= '0;
      ex_b     <= '0;
      ex_imm   <= '0;
      ex_dest  <= '0;
      ex_pc4   <= '0;
    end else begin
      ex_valid <= id_valid && id_legal;
      ex_ctrl  <= id_ctrl;
      ex_a     <= id_a;
      ex_b     <= id_b;
      ex_imm   <= id_imm;
      ex_dest  <= id_dest;
      ex_pc4   <= id_pc4;
    end
  end

  // ---------------- execute ----------------
  logic [XLEN-1:0] ex_opb, ex_s;

  assign ex_opb = ex_ctrl.use_imm ? ex_imm : ex_b;

  mpipe_alu #(.W(XLEN)) u_alu (
    .a  (ex_a),
    .b  (ex_opb),
    .op (ex_ctrl.alu),
    .y  (ex_s)
  );

  assign br_take   = ex_valid && ex_ctrl.branch && (ex_a == ex_b);
  assign br_target = ex_pc4 + {ex_imm[PC_W-3:0], 2'b00};

  logic              mem_valid;
  logic              mem_rd, mem_wr, mem_rw;
  logic [XLEN-1:0]   mem_s, mem_b;
  logic [REG_AW-1:0] mem_dest;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_rw    <= 1'b0;
      mem_s     <= '0;
      mem_b     <= '0;
      mem_dest  <= '0;
    end else begin
      mem_valid <= ex_valid;
      mem_rd    <= ex_ctrl.mem_rd;
      mem_wr    <= ex_ctrl.mem_wr;
      mem_rw    <= ex_ctrl.reg_wr;
      mem_s     <= ex_s;
      mem_b     <= ex_b;
      mem_dest  <= ex_dest;
    end
  end

  // ---------------- memory (ALU results pass straight through) ----------------
  logic [XLEN-1:0] mem_m;

  assign dmem_addr  = mem_s[DMEM_AW+1:2];
  assign dmem_we    = mem_valid && mem_wr;
  assign dmem_wdata = mem_b;
  assign mem_m      = mem_rd ? dmem_rdata : mem_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_rw    <= 1'b0;
      wb_dest  <= '0;
      wb_m     <= '0;
    end else begin
      wb_valid <= mem_valid;
      wb_rw    <= mem_rw;
      wb_dest  <= mem_dest;
      wb_m     <= mem_m;
    end
  end

  // ---------------- writeback ----------------
  assign wr_en   = wb_valid && wb_rw && (wb_dest != '0);
  assign wr_addr = wb_dest;
  assign wr_data = wb_m;

  // ---------------- assertions ----------------
  a_r7_fetch_redirect: assert property (@(posedge clk) disable iff (rst)
    br_take |=> (pc == $past(br_target)));

  a_r7_delay_slot_kept: assert property (@(posedge clk) disable iff (rst)
    (br_take && id_valid && id_legal) |=> ex_valid);

  a_r5_write_follows_mem: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(mem_valid && mem_rw));

  a_r4_store_no_write: assert property (@(posedge clk) disable iff (rst)
    dmem_we |=> !wr_en);

endmodule

// File: tb/mpipe_core_test.sv
module mpipe_core_test;

  localparam int IAW = 10;
  localparam int DAW = 10;
  localparam int IW  = 1 << IAW;
  localparam int DW  = 1 << DAW;
  localparam int MAXE = 256;

  localparam logic [5:0] T_REG = 6'h00, T_ADDI = 6'h08, T_ORI = 6'h0D;
  localparam logic [5:0] T_LW = 6'h23, T_SW = 6'h2B, T_BEQ = 6'h04;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IAW-1:0] imem_addr;
  logic [31:0]    imem_data;
  logic [DAW-1:0] dmem_addr;
  logic           dmem_we;
  logic [31:0]    dmem_wdata, dmem_rdata;
  logic           wr_en;
  logic [4:0]     wr_addr;
  logic [31:0]    wr_data;

  logic [31:0] imem [IW];
  logic [31:0] dmem [DW];
  logic [31:0] mmem [DW];

  int n_chk = 0;
  int n_bad = 0;
  int plen;
  int cyc;
  logic mon_on = 1'b0;
  logic dm_load = 1'b0;

  int ne_r, ne_m, no_r, no_m;
  logic [4:0]     er_a [MAXE];
  logic [31:0]    er_d [MAXE];
  int             er_c [MAXE];
  string          er_t [MAXE];
  logic [DAW-1:0] em_a [MAXE];
  logic [31:0]    em_d [MAXE];
  int             em_c [MAXE];
  logic [4:0]     or_a [MAXE];
  logic [31:0]    or_d [MAXE];
  int             or_c [MAXE];
  logic [DAW-1:0] om_a [MAXE];
  logic [31:0]    om_d [MAXE];
  int             om_c [MAXE];

  mpipe_core #(.IMEM_AW(IAW), .DMEM_AW(DAW)) uut (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_we(dmem_we),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] dinit(int i);
    return 32'h1234_0000 + 32'(i) * 32'h0000_9E37;
  endfunction

  assign imem_data  = imem[imem_addr];
  assign dmem_rdata = dmem[dmem_addr];

  always @(posedge clk) begin
    if (dm_load) begin
      for (int i = 0; i < DW; i++) dmem[i] <= dinit(i);
    end else if (dmem_we) begin
      dmem[dmem_addr] <= dmem_wdata;
    end
  end

  always @(negedge clk) begin
    if (mon_on) begin
      cyc = cyc + 1;
      if (wr_en && no_r < MAXE) begin
        or_a[no_r] = wr_addr; or_d[no_r] = wr_data; or_c[no_r] = cyc;
        no_r = no_r + 1;
      end
      if (dmem_we && no_m < MAXE) begin
        om_a[no_m] = dmem_addr; om_d[no_m] = dmem_wdata; om_c[no_m] = cyc;
        no_m = no_m + 1;
      end
    end
  end

  task automatic check(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic [31:0] e_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
    return {T_REG, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] e_i(input logic [5:0] op, input int rt, input int rs, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic clr_prog();
    for (int i = 0; i < IW; i++) imem[i] = '0;
    plen = 0;
  endtask

  task automatic put(input logic [31:0] w);
    imem[plen] = w;
    plen++;
  endtask

  // Instruction-level reference: one delay slot, cancelled slot after it.
  task automatic run_model();
    logic [31:0] r [32];
    logic [31:0] ins, a, b, se, ze, res, cur, pc, npc;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, sh;
    logic [DAW-1:0] wa;
    int slot;
    bit sq, take;
    for (int i = 0; i < 32; i++) r[i] = '0;
    for (int i = 0; i < DW; i++) mmem[i] = dinit(i);
    ne_r = 0; ne_m = 0;
    pc = 0; npc = 4; slot = 0; sq = 0;
    for (int step = 0; step < 400 && pc < 32'(plen * 4); step++) begin
      ins = imem[pc[IAW+1:2]];
      cur = pc; pc = npc; npc = npc + 4;
      op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
      sh = ins[10:6]; fn = ins[5:0];
      se = {{16{ins[15]}}, ins[15:0]};
      ze = {16'h0, ins[15:0]};
      a = r[rs]; b = r[rt];
      take = 0;
      case (op)
        T_REG: if (sh == 0) begin
          case (fn)
            6'h20: begin res = a + b; if (rd != 0) begin r[rd] = res; er_a[ne_r] = rd; er_d[ne_r] = res; er_c[ne_r] = slot + 4; er_t[ne_r] = "R2"; ne_r++; end end
            6'h22: begin res = a - b; if (rd != 0) begin r[rd] = res; er_a[ne_r] = rd; er_d[ne_r] = res; er_c[ne_r] = slot + 4; er_t[ne_r] = "R2"; ne_r++; end end
            6'h24: begin res = a & b; if (rd != 0) begin r[rd] = res; er_a[ne_r] = rd; er_d[ne_r] = res; er_c[ne_r] = slot + 4; er_t[ne_r] = "R2"; ne_r++; end end
            6'h25: begin res = a | b; if (rd != 0) begin r[rd] = res; er_a[ne_r] = rd; er_d[ne_r] = res; er_c[ne_r] = slot + 4; er_t[ne_r] = "R2"; ne_r++; end end
            default: ;
          endcase
        end
        T_ADDI, T_ORI: begin
          res = (op == T_ADDI) ? a + se : a | ze;
          if (rt != 0) begin r[rt] = res; er_a[ne_r] = rt; er_d[ne_r] = res; er_c[ne_r] = slot + 4; er_t[ne_r] = "R3"; ne_r++; end
        end
        T_LW: begin
          res = a + se; wa = res[DAW+1:2];
          if (rt != 0) begin r[rt] = mmem[wa]; er_a[ne_r] = rt; er_d[ne_r] = mmem[wa]; er_c[ne_r] = slot + 4; er_t[ne_r] = "R4"; ne_r++; end
        end
        T_SW: begin
          res = a + se; wa = res[DAW+1:2];
          mmem[wa] = b;
          em_a[ne_m] = wa; em_d[ne_m] = b; em_c[ne_m] = slot + 3; ne_m++;
        end
        T_BEQ: if (a == b) begin
          npc = cur + 4 + (se << 2);
          take = 1;
        end
        default: ;
      endcase
      slot++;
      if (sq) begin slot++; sq = 0; end
      if (take) sq = 1;
    end
  endtask

  task automatic run_test(input string name, input string ctag);
    run_model();
    rst = 1'b1; mon_on = 1'b0; no_r = 0; no_m = 0;
    dm_load = 1'b1;
    @(posedge clk); #1 dm_load = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(imem_addr == '0 && !wr_en && !dmem_we,
          $sformatf("R1 %s: in reset addr=%0d wr_en=%b st=%b exp 0/0/0", name, imem_addr, wr_en, dmem_we));
    rst = 1'b0; cyc = 0;
    #1 mon_on = 1'b1;
    repeat (plen * 2 + 30) @(negedge clk);
    #1 mon_on = 1'b0;
    check(no_r == ne_r, $sformatf("%s %s: register writes got %0d exp %0d", ctag, name, no_r, ne_r));
    check(no_m == ne_m, $sformatf("R11 %s: stores got %0d exp %0d", name, no_m, ne_m));
    for (int i = 0; i < ne_r && i < no_r; i++)
      check(or_a[i] == er_a[i] && or_d[i] == er_d[i] && or_c[i] == er_c[i],
            $sformatf("%s/R5 %s write %0d: got r%0d=%h @%0d exp r%0d=%h @%0d",
                      er_t[i], name, i, or_a[i], or_d[i], or_c[i], er_a[i], er_d[i], er_c[i]));
    for (int i = 0; i < ne_m && i < no_m; i++)
      check(om_a[i] == em_a[i] && om_d[i] == em_d[i] && om_c[i] == em_c[i],
            $sformatf("R11 %s store %0d: got [%0d]=%h @%0d exp [%0d]=%h @%0d",
                      name, i, om_a[i], om_d[i], om_c[i], em_a[i], em_d[i], em_c[i]));
  endtask

  task automatic gen_random(input int n);
    int l1, l2, k, d, s1, s2;
    l1 = 0; l2 = 0;
    clr_prog();
    for (int j = 0; j < n; j++) begin
      k = $urandom % 10;
      d = $urandom % 16;
      s1 = $urandom % 16;
      for (int t = 0; t < 40 && s1 != 0 && (s1 == l1 || s1 == l2); t++) s1 = $urandom % 16;
      if (s1 != 0 && (s1 == l1 || s1 == l2)) s1 = 0;
      s2 = $urandom % 16;
      for (int t = 0; t < 40 && s2 != 0 && (s2 == l1 || s2 == l2); t++) s2 = $urandom % 16;
      if (s2 != 0 && (s2 == l1 || s2 == l2)) s2 = 0;
      case (k)
        0: put(e_r(6'h20, d, s1, s2));
        1: put(e_r(6'h22, d, s1, s2));
        2: put(e_r(6'h24, d, s1, s2));
        3: put(e_r(6'h25, d, s1, s2));
        4, 9: put(e_i(T_ADDI, d, s1, int'($urandom % 65536)));
        5: put(e_i(T_ORI, d, s1, int'($urandom % 65536)));
        6: put(e_i(T_LW, d, 0, int'(($urandom % 64) * 4)));
        7: begin put(e_i(T_SW, s2, 0, int'(($urandom % 64) * 4))); d = 0; end
        default: begin put({6'h3F, 26'($urandom)}); d = 0; end
      endcase
      l2 = l1; l1 = d;
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd7321);

    // Straight-line ALU program: R2 R3 R6 R9 R10, write timing R5.
    clr_prog();
    put(e_i(T_ADDI, 1, 0, 5));
    put(e_i(T_ADDI, 2, 0, -3));
    put(e_i(T_ORI, 3, 0, 16'h8001));
    put(e_r(6'h20, 4, 1, 1));
    put(e_r(6'h22, 5, 2, 1));
    put(e_r(6'h24, 6, 3, 1));
    put(e_r(6'h25, 7, 4, 3));
    put(e_i(T_ADDI, 0, 1, 7));
    put(32'hFC00_0000);
    put(e_r(6'h20, 8, 0, 7));
    put(e_r(6'h20, 9, 8, 0) | 32'h0000_0040);
    run_test("alu", "R6 R9 R10");

    // Loads and stores: R4 R11.
    clr_prog();
    put(e_i(T_LW, 1, 0, 16));
    put(e_i(T_ADDI, 2, 0, 16'h77));
    put(e_i(T_ORI, 3, 0, 12));
    put(32'h0);
    put(32'h0);
    put(e_i(T_SW, 2, 3, 8));
    put(32'h0); put(32'h0); put(32'h0);
    put(e_i(T_LW, 4, 0, 20));
    put(e_i(T_LW, 5, 3, -4));
    put(e_i(T_SW, 1, 0, 0));
    put(e_i(T_LW, 0, 0, 4));
    run_test("memory", "R4");

    // Branches: R7 taken, R8 not taken, target at cancelled slot.
    clr_prog();
    put(e_i(T_ADDI, 1, 0, 9));
    put(e_i(T_ADDI, 2, 0, 9));
    put(32'h0);
    put(32'h0);
    put(e_i(T_BEQ, 2, 1, 3));
    put(e_i(T_ADDI, 3, 0, 1));
    put(e_i(T_ADDI, 4, 0, 2));
    put(e_i(T_ADDI, 5, 0, 3));
    put(e_i(T_ADDI, 6, 0, 4));
    put(e_i(T_BEQ, 0, 1, 5));
    put(e_i(T_ADDI, 7, 0, 5));
    put(e_i(T_ADDI, 8, 0, 6));
    put(e_i(T_BEQ, 0, 0, 1));
    put(e_i(T_ADDI, 9, 0, 7));
    put(e_i(T_ADDI, 10, 0, 8));
    run_test("branch", "R7 R8");

    for (int p = 0; p < 4; p++) begin
      gen_random(48);
      run_test($sformatf("random%0d", p), "R2 R3 R4");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule